// File: doc/BRIEF.md
# Three-Level PWM Input Decoder

This block sits behind a pair of window comparators that watch a three-level PWM control line. Each clock cycle it classifies the comparator pair as a high level, a low level or a mid-level (tri-state) input, and from that history it produces two registered outputs for a downstream gate sequencer: a level command (`cmd_high_o`, 1 asks for the high-side switch, 0 for the low-side switch) and a shutdown flag that forces both gates off.

A mid-level input is not trusted right away. It becomes a shutdown only once it has been seen for `HOLD_CYCLES` consecutive samples. Until then the previous command stays in force. Leaving the window goes straight to the new level on the next edge, with no qualification, so that a controller can bring a shed phase back quickly. A floating line rests inside the window, so an unconnected input ends in shutdown. After reset the decoder reports shutdown until it sees its first valid level.

The comparator outputs are assumed to be synchronised already. A state with both comparators asserted cannot happen on a real line, and the decoder treats it as a mid-level sample.

Top module: `pwm3_level_decoder`

## Requirements
- R1: The input pair is decoded with `above_hi_i` and `below_lo_i` as follows: 1/0 is a high level, 0/1 is a low level, and 0/0 is a mid-level sample.
- R2: While `rst_n` is sampled low, the next clock edge sets `shutdown_o` to 1 and `cmd_high_o` to 0.
- R3: A high-level sample sets `cmd_high_o` to 1 and `shutdown_o` to 0 at the next clock edge.
- R4: A low-level sample sets `cmd_high_o` to 0 and `shutdown_o` to 0 at the next clock edge.
- R5: A mid-level sample that is not yet the `HOLD_CYCLES`-th in a row leaves both outputs unchanged.
- R6: At the edge that takes the `HOLD_CYCLES`-th consecutive mid-level sample, `shutdown_o` becomes 1. It stays 1 while further mid-level samples arrive, and `cmd_high_o` keeps its value.
- R7: From shutdown, a high or low sample clears `shutdown_o` and sets the command at the very next edge, with no hold-off.
- R8: Any high or low sample restarts the mid-level count, so a later mid-level run needs `HOLD_CYCLES` fresh consecutive samples.
- R9: The illegal pair 1/1 counts as a mid-level sample, both for the hold-off count and for the shutdown it leads to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| above_hi_i | input | 1 | Comparator: line above the high threshold |
| below_lo_i | input | 1 | Comparator: line below the low threshold |
| cmd_high_o | output | 1 | Level command: 1 selects the high-side switch, 0 the low-side switch |
| shutdown_o | output | 1 | 1 forces both gates off |

## Verification
The bench builds the decoder with `HOLD_CYCLES` set to 4. With that value, every sequence of six input symbols drawn from all four comparator combinations can be applied from reset. The bench steps through all 4096 such sequences, so it covers a hold-off that just expires, one that is one sample short, runs that the illegal pair interrupts or extends, and every exit from shutdown to either level. Directed cases before the sweep check each comparator combination on its own and a restarted mid-level run.

// File: rtl/pwm3_pkg.sv
// Shared types for the three-level PWM input decoder.
// Assumes nothing beyond the standard types.
package pwm3_pkg;

    // Level decoded from one comparator sample
    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

endpackage

// File: rtl/pwm3_window_classify.sv
// Combinational window classifier.
// Maps the two comparator outputs to a level. Assumes the inputs are already
// synchronised. The impossible both-asserted state is mapped to mid-level.
module pwm3_window_classify
    import pwm3_pkg::*;
(
    input  logic above_hi,
    input  logic below_lo,
    output lvl_e level,
    output logic is_mid
);

    // Decode the comparator pair into a level
    always_comb begin
        unique case ({above_hi, below_lo})
            2'b10:   level = LVL_HIGH;
            2'b01:   level = LVL_LOW;
            default: level = LVL_MID;
        endcase
    end

    // Flag for the hold-off timer
    assign is_mid = (level == LVL_MID);

endmodule

// File: rtl/pwm3_holdoff_timer.sv
// Hold-off timer for mid-level samples.
// Counts consecutive mid-level samples. 'expire' is high on a sample that is
// at least the HOLD_CYCLES-th in a row. Any valid level clears the count.
// Assumes HOLD_CYCLES >= 1.
module pwm3_holdoff_timer #(
    parameter int HOLD_CYCLES = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_mid,
    output logic expire
);

    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] run_q;

    // Count mid-level samples, saturating one below the hold-off length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!is_mid) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    // The current sample completes the hold-off when the count is at its end
    assign expire = is_mid && (run_q == LAST);

    // The count never passes its saturation point (R6)
    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert_run_bound_R6: assert (run_q <= LAST)
                else $error("hold-off count beyond limit");
        end
    end

    // A valid level always leaves the count cleared (R8)
    assert_run_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mid |=> run_q == '0);

endmodule

// File: rtl/pwm3_cmd_resolve.sv
// Command resolver.
// Holds the level command and the shutdown flag. Valid levels act at once.
// A mid-level sample keeps both outputs until the timer reports expiry, and
// then raises shutdown. Reset yields shutdown with a low command.
module pwm3_cmd_resolve
    import pwm3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lvl_e level,
    input  logic expire,
    output logic cmd_high,
    output logic shutdown
);

    // Register the command and shutdown state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_high <= 1'b0;
            shutdown <= 1'b1;
        end else begin
            unique case (level)
                LVL_HIGH: begin
                    cmd_high <= 1'b1;
                    shutdown <= 1'b0;
                end
                LVL_LOW: begin
                    cmd_high <= 1'b0;
                    shutdown <= 1'b0;
                end
                default: begin
                    if (expire) shutdown <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm3_level_decoder.sv
// Three-level PWM input decoder (top).
// Classifies the comparator pair, qualifies mid-level entry with a
// HOLD_CYCLES hold-off, and leaves the window without delay.
// Assumes synchronised comparator inputs.
module pwm3_level_decoder
    import pwm3_pkg::*;
#(
    parameter int HOLD_CYCLES = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi_i,
    input  logic below_lo_i,
    output logic cmd_high_o,
    output logic shutdown_o
);

    lvl_e level;
    logic is_mid;
    logic expire;

    pwm3_window_classify u_classify (
        .above_hi (above_hi_i),
        .below_lo (below_lo_i),
        .level    (level),
        .is_mid   (is_mid)
    );

    pwm3_holdoff_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .is_mid (is_mid),
        .expire (expire)
    );

    pwm3_cmd_resolve u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .expire   (expire),
        .cmd_high (cmd_high_o),
        .shutdown (shutdown_o)
    );

    // Reset leaves the decoder in shutdown with a low command (R2)
    assert_reset_state_R2: assert property (@(posedge clk)
        !rst_n |=> (shutdown_o && !cmd_high_o));

    // A high level is followed by a high command, out of shutdown (R3, R7)
    assert_high_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (above_hi_i && !below_lo_i) |=> (cmd_high_o && !shutdown_o));

    // A low level is followed by a low command, out of shutdown (R4, R7)
    assert_low_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!above_hi_i && below_lo_i) |=> (!cmd_high_o && !shutdown_o));

    // A mid-level sample before expiry leaves the outputs as they were (R5)
    assert_holdoff_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (above_hi_i == below_lo_i && !expire) |=>
            ($stable(shutdown_o) && $stable(cmd_high_o)));

    // An expired hold-off gives shutdown and keeps the command (R6, R9)
    assert_expire_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (shutdown_o && $stable(cmd_high_o)));

endmodule

// File: tb/pwm3_level_decoder_test.sv
// Bench for the three-level PWM input decoder.
// Directed cases followed by an exhaustive sweep of all six-symbol sequences
// with HOLD_CYCLES = 4. Symbol encoding: bit1 = above_hi_i, bit0 = below_lo_i.
module pwm3_level_decoder_test;

    localparam int HOLD = 4;
    localparam int SEQ_LEN = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_hi = 1'b0;
    logic below_lo = 1'b0;
    logic cmd_high;
    logic shutdown;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Reference state, computed from the requirements
    logic exp_cmd;
    logic exp_sd;
    int   exp_run;

    pwm3_level_decoder #(.HOLD_CYCLES(HOLD)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .above_hi_i (above_hi),
        .below_lo_i (below_lo),
        .cmd_high_o (cmd_high),
        .shutdown_o (shutdown)
    );

    always #2 clk = ~clk;

    // Compare both outputs against the reference
    task automatic check(input string tag);
        total++;
        if (shutdown !== exp_sd || cmd_high !== exp_cmd) begin
            bad++;
            $display("FAIL %s: shutdown=%b cmd_high=%b expected shutdown=%b cmd_high=%b",
                     tag, shutdown, cmd_high, exp_sd, exp_cmd);
        end
    endtask

    // Apply one reset cycle and check the reset state (R2)
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        above_hi = 1'b0;
        below_lo = 1'b0;
        @(posedge clk);
        #1;
        exp_cmd = 1'b0;
        exp_sd  = 1'b1;
        exp_run = 0;
        check("R2");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply one symbol, update the reference and check after the edge
    task automatic step(input logic [1:0] sym);
        string tag;
        logic  prev_sd;
        @(negedge clk);
        above_hi = sym[1];
        below_lo = sym[0];
        @(posedge clk);
        #1;
        prev_sd = exp_sd;
        if (sym == 2'b10) begin
            exp_cmd = 1'b1; exp_sd = 1'b0; exp_run = 0;
            tag = prev_sd ? "R7" : "R3";
        end else if (sym == 2'b01) begin
            exp_cmd = 1'b0; exp_sd = 1'b0; exp_run = 0;
            tag = prev_sd ? "R7" : "R4";
        end else begin
            if (exp_run < HOLD) exp_run++;
            if (exp_run >= HOLD) exp_sd = 1'b1;
            if (sym == 2'b11)               tag = "R9";
            else if (exp_sd && !prev_sd)    tag = "R6";
            else                            tag = "R5";
        end
        check(tag);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        exp_cmd = 1'b0;
        exp_sd  = 1'b1;
        exp_run = 0;

        // R1: each comparator combination decoded on its own
        do_reset();
        step(2'b10);                       // R1: high
        step(2'b01);                       // R1: low
        step(2'b00);                       // R1: mid keeps low command
        step(2'b10);

        // R8: an interrupted mid-level run restarts its count
        step(2'b00); step(2'b00); step(2'b00);
        step(2'b01);                       // restart
        step(2'b00); step(2'b00); step(2'b00);
        total++;
        if (shutdown !== 1'b0) begin
            bad++;
            $display("FAIL R8: shutdown=%b expected 0", shutdown);
        end
        step(2'b00);                       // fourth fresh sample: shutdown
        total++;
        if (shutdown !== 1'b1) begin
            bad++;
            $display("FAIL R8: shutdown=%b expected 1", shutdown);
        end

        // Reset held with a floating line stays in shutdown (R2)
        do_reset();
        step(2'b00);

        // Exhaustive sweep of all symbol sequences of length SEQ_LEN
        for (int s = 0; s < (1 << (2 * SEQ_LEN)); s++) begin
            do_reset();
            for (int k = 0; k < SEQ_LEN; k++) begin
                step(2'(s >> (2 * k)));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule